// File: doc/BRIEF.md
# Voltage Regulator Fault Supervisor

This block supervises one multiphase core rail. Every clock it compares the digitised rail voltage, the total current, each phase current, each phase temperature and the controller temperature against programmable limits. Each fault class has its own filter: a short cycle count for overvoltage, a blanking window for undervoltage, and millisecond debounce for overtemperature. Each class also has its own action: a latched trip, a retry-limited hiccup, a soft-off, or the isolation of one phase. The block drives the rail enable, a per-phase disable mask, a derate request and power-good.

Every detection cycle produces one log record, marked by a single-cycle strobe. The record carries a bitmask of every fault class seen in that cycle, the rail identity, the phase involved, a current and temperature snapshot, and a cycle timestamp. When several classes fire together, one action is applied and the highest-ranked class chooses it. All timers count a millisecond tick. The tick is derived from the clock by a parameterised divider.

Top module: `vr_fault_policy`

## Requirements
- R1: Overvoltage (v_code > ov_lim) trips only after it has been seen for ov_filt+1 consecutive cycles while the rail is on. A shorter excursion does nothing. A trip turns rail_en and pgood off at the edge where it is detected. The rail stays off until a clr_latch pulse. After that pulse, with run_req high, the rail starts again.
- R2: Undervoltage (v_code < uv_lim) is ignored during start-up and for uv_blank ticks after entering run or after a load_step pulse. After that window it turns the rail off, and the rail stays off while run_req stays high. It restarts only after run_req has been low.
- R3: Total overcurrent (i_total > oct_lim) while running turns the rail off for oc_cool ticks and then restarts it. The first retry_max such hiccups restart the rail. The next one latches it off until clr_latch.
- R4: The retry count returns to zero once the rail has run for good_len ticks without a fault.
- R5: Phase overcurrent (phase current > oph_lim) sets that phase's bit in ph_off and the rail keeps running. The bit clears after ph_cool ticks.
- R6: Any temperature above t_warn raises derate on the next cycle (strictly greater; equal does not). A phase at or above t_hot for hot_deb ticks sets its ph_off bit. The controller at or above t_hot for hot_deb ticks latches the rail off. Shorter hot spells gate nothing.
- R7: Each detection cycle gives one log_vld pulse in the following cycle. log_cause bits are: 0 overvoltage, 1 total overcurrent, 2 start-up short, 3 undervoltage, 4 phase overcurrent, 5 phase overtemperature, 6 controller overtemperature. log_rail is RAIL_ID. log_phase is the lowest faulting phase. log_cur and log_tmp hold that phase's current and temperature, or i_total and t_ctrl when no phase faulted. log_ts counts clock cycles.
- R8: pgood is high only in the running state, which begins start_len ticks after the rail is enabled. pgood is never high while rail_en is low.
- R9: A start-up short (i_total > short_lim during the start-up ramp) turns the rail off at the next edge. Retry k waits oc_cool shifted left by k ticks, so the waits double. After retry_max retries the rail latches off.
- R10: When faults coincide, one action is applied, chosen in this order: overvoltage, then overcurrent, then undervoltage, then overtemperature. log_cause still lists every class that fired.
- R11: During reset rail_en, pgood, ph_off, derate and log_vld are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | 1 | Request to run the rail |
| clr_latch | input | 1 | Clears a latched-off state |
| load_step | input | 1 | Restarts the undervoltage blanking window |
| v_code | input | VW | Rail voltage sample |
| i_total | input | IW | Total rail current |
| i_phase | input | NPH*IW | Phase currents, phase k at bits k*IW |
| t_phase | input | NPH*TW | Phase temperatures, phase k at bits k*TW |
| t_ctrl | input | TW | Controller temperature |
| ov_lim | input | VW | Overvoltage limit |
| uv_lim | input | VW | Undervoltage limit |
| oct_lim | input | IW | Total overcurrent limit |
| short_lim | input | IW | Start-up short limit |
| oph_lim | input | IW | Phase overcurrent limit |
| t_warn | input | TW | Derate temperature |
| t_hot | input | TW | Gating temperature |
| ov_filt | input | FW | Overvoltage filter, cycles |
| uv_blank | input | CW | Undervoltage blanking, ticks |
| start_len | input | CW | Start-up ramp length, ticks |
| oc_cool | input | CW | Hiccup cool-down base, ticks |
| ph_cool | input | CW | Phase re-add delay, ticks |
| hot_deb | input | CW | Overtemperature debounce, ticks |
| good_len | input | CW | Fault-free time that clears retries, ticks |
| retry_max | input | RW | Hiccups allowed before latching |
| rail_en | output | 1 | Rail enable |
| ph_off | output | NPH | Per-phase disable mask |
| derate | output | 1 | Derate request |
| pgood | output | 1 | Power-good |
| log_vld | output | 1 | Log record strobe |
| log_ts | output | TSW | Detection timestamp, cycles |
| log_cause | output | 7 | Fault class bitmask |
| log_rail | output | 4 | Rail identity |
| log_phase | output | PW | Phase identity |
| log_cur | output | IW | Current snapshot |
| log_tmp | output | TW | Temperature snapshot |

## Verification
A wrong policy state shows at rail_en and pgood on the edge that follows the detection. For example, a hiccup taken where a latch was due brings rail_en back within one cool-down plus one ramp, so the bench checks that the rail is still off well after that window has passed. A retry count that is not cleared, or that is cleared too early, changes whether the third trip in a row latches or restarts, and that shows within one cool-down period. A phase cool-down timer that is wrong leaves a ph_off bit set too long or too short, and the bench samples ph_off on both sides of the expected re-add time.

// File: rtl/vr_fault_policy.sv
module vr_fault_policy #(
  parameter int NPH      = 4,
  parameter int VW       = 12,
  parameter int IW       = 12,
  parameter int TW       = 10,
  parameter int CW       = 16,
  parameter int FW       = 4,
  parameter int RW       = 3,
  parameter int TSW      = 32,
  parameter int TICK_DIV = 100000,
  parameter int RAIL_ID  = 0,
  localparam int PW      = (NPH > 1) ? $clog2(NPH) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_req,
  input  logic              clr_latch,
  input  logic              load_step,
  input  logic [VW-1:0]     v_code,
  input  logic [IW-1:0]     i_total,
  input  logic [NPH*IW-1:0] i_phase,
  input  logic [NPH*TW-1:0] t_phase,
  input  logic [TW-1:0]     t_ctrl,
  input  logic [VW-1:0]     ov_lim,
  input  logic [VW-1:0]     uv_lim,
  input  logic [IW-1:0]     oct_lim,
  input  logic [IW-1:0]     short_lim,
  input  logic [IW-1:0]     oph_lim,
  input  logic [TW-1:0]     t_warn,
  input  logic [TW-1:0]     t_hot,
  input  logic [FW-1:0]     ov_filt,
  input  logic [CW-1:0]     uv_blank,
  input  logic [CW-1:0]     start_len,
  input  logic [CW-1:0]     oc_cool,
  input  logic [CW-1:0]     ph_cool,
  input  logic [CW-1:0]     hot_deb,
  input  logic [CW-1:0]     good_len,
  input  logic [RW-1:0]     retry_max,
  output logic              rail_en,
  output logic [NPH-1:0]    ph_off,
  output logic              derate,
  output logic              pgood,
  output logic              log_vld,
  output logic [TSW-1:0]    log_ts,
  output logic [6:0]        log_cause,
  output logic [3:0]        log_rail,
  output logic [PW-1:0]     log_phase,
  output logic [IW-1:0]     log_cur,
  output logic [TW-1:0]     log_tmp
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  typedef enum logic [2:0] {S_OFF, S_RAMP, S_RUN, S_COOL, S_HOLD, S_LATCH} st_t;
  st_t st;

  logic [DW-1:0]  div_q;
  logic [TSW-1:0] ts_q;
  logic           tick;
  assign tick = (div_q == DW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q <= '0;
      ts_q  <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      ts_q  <= ts_q + 1'b1;
    end

  logic ramp, run, live;
  assign ramp    = (st == S_RAMP);
  assign run     = (st == S_RUN);
  assign live    = ramp | run;
  assign rail_en = live;
  assign pgood   = run;
  assign log_rail = 4'(RAIL_ID);

  logic [FW-1:0] ov_cnt;
  logic          ov_raw;
  assign ov_raw = (v_code > ov_lim);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              ov_cnt <= '0;
    else if (!ov_raw)        ov_cnt <= '0;
    else if (ov_cnt != '1)   ov_cnt <= ov_cnt + 1'b1;

  logic [IW-1:0] iph [NPH];
  logic [TW-1:0] tph [NPH];
  logic [CW-1:0] pc_q [NPH];
  logic [CW-1:0] hc_q [NPH];
  logic [CW-1:0] blank_q, scnt_q, ccnt_q, gcnt_q, hcc_q;
  logic [RW-1:0] retry_q;
  logic [NPH-1:0] oph, phot;
  logic [PW-1:0]  pid;
  logic           warn, phf;

  always_comb begin
    oph  = '0;
    phot = '0;
    pid  = '0;
    warn = (t_ctrl > t_warn);
    for (int k = 0; k < NPH; k++) begin
      iph[k]  = i_phase[k*IW +: IW];
      tph[k]  = t_phase[k*TW +: TW];
      oph[k]  = run && !ph_off[k] && (iph[k] > oph_lim);
      phot[k] = run && !ph_off[k] && (tph[k] >= t_hot) && (hc_q[k] >= hot_deb);
      if (tph[k] > t_warn) warn = 1'b1;
    end
    for (int k = NPH - 1; k >= 0; k--)
      if (oph[k] || phot[k]) pid = PW'(k);
  end
  assign phf = |(oph | phot);

  logic f_ov, f_oct, f_sht, f_uv, f_chot;
  assign f_ov   = live && ov_raw && (ov_cnt >= ov_filt);
  assign f_oct  = run && (i_total > oct_lim);
  assign f_sht  = ramp && (i_total > short_lim);
  assign f_uv   = run && (blank_q == '0) && (v_code < uv_lim);
  assign f_chot = live && (t_ctrl >= t_hot) && (hcc_q >= hot_deb);

  logic [6:0] cause;
  assign cause = {f_chot, |phot, |oph, f_uv, f_sht, f_oct, f_ov};

  logic [CW-1:0] backoff;
  logic          spent;
  assign backoff = oc_cool << retry_q;
  assign spent   = (retry_q >= retry_max);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      blank_q <= '0;
      hcc_q   <= '0;
      derate  <= 1'b0;
    end else begin
      derate <= warn;
      if (ramp || load_step)          blank_q <= uv_blank;
      else if (tick && blank_q != '0) blank_q <= blank_q - 1'b1;
      if (t_ctrl < t_hot)             hcc_q <= '0;
      else if (tick && hcc_q < hot_deb) hcc_q <= hcc_q + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph_off <= '0;
      for (int k = 0; k < NPH; k++) begin
        pc_q[k] <= '0;
        hc_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < NPH; k++) begin
        if (tph[k] < t_hot)                 hc_q[k] <= '0;
        else if (tick && hc_q[k] < hot_deb) hc_q[k] <= hc_q[k] + 1'b1;
        if (oph[k] || phot[k]) begin
          ph_off[k] <= 1'b1;
          pc_q[k]   <= ph_cool;
        end else if (ph_off[k] && pc_q[k] == '0) begin
          ph_off[k] <= 1'b0;
        end else if (tick && pc_q[k] != '0) begin
          pc_q[k] <= pc_q[k] - 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_OFF;
      scnt_q  <= '0;
      ccnt_q  <= '0;
      gcnt_q  <= '0;
      retry_q <= '0;
    end else begin
      if (!run)                              gcnt_q <= '0;
      else if (tick && gcnt_q < good_len)    gcnt_q <= gcnt_q + 1'b1;
      if (run && gcnt_q >= good_len)         retry_q <= '0;
      case (st)
        S_OFF:
          if (run_req) begin
            st     <= S_RAMP;
            scnt_q <= start_len;
          end
        S_RAMP:
          if (f_ov) st <= S_LATCH;
          else if (f_sht) begin
            if (spent) st <= S_LATCH;
            else begin
              st      <= S_COOL;
              ccnt_q  <= backoff;
              retry_q <= retry_q + 1'b1;
            end
          end
          else if (f_chot)            st <= S_LATCH;
          else if (!run_req)          st <= S_OFF;
          else if (scnt_q == '0)      st <= S_RUN;
          else if (tick)              scnt_q <= scnt_q - 1'b1;
        S_RUN:
          if (f_ov) st <= S_LATCH;
          else if (f_oct) begin
            if (spent) st <= S_LATCH;
            else begin
              st      <= S_COOL;
              ccnt_q  <= oc_cool;
              retry_q <= retry_q + 1'b1;
            end
          end
          else if (f_uv)              st <= S_HOLD;
          else if (f_chot)            st <= S_LATCH;
          else if (!run_req)          st <= S_OFF;
        S_COOL:
          if (ccnt_q == '0) begin
            if (run_req) begin
              st     <= S_RAMP;
              scnt_q <= start_len;
            end else st <= S_OFF;
          end else if (tick) ccnt_q <= ccnt_q - 1'b1;
        S_HOLD:
          if (!run_req) st <= S_OFF;
        S_LATCH:
          if (clr_latch) begin
            st      <= S_OFF;
            retry_q <= '0;
          end
        default: st <= S_OFF;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      log_vld   <= 1'b0;
      log_ts    <= '0;
      log_cause <= '0;
      log_phase <= '0;
      log_cur   <= '0;
      log_tmp   <= '0;
    end else begin
      log_vld <= |cause;
      if (|cause) begin
        log_ts    <= ts_q;
        log_cause <= cause;
        log_phase <= pid;
        log_cur   <= phf ? iph[pid] : i_total;
        log_tmp   <= phf ? tph[pid] : t_ctrl;
      end
    end
endmodule

// File: rtl/vr_fault_policy_chk.sv
module vr_fault_policy_chk #(
  parameter int NPH = 4
)(
  input logic           clk,
  input logic           rst_n,
  input logic           rail_en,
  input logic           pgood,
  input logic [NPH-1:0] ph_off,
  input logic           log_vld,
  input logic [6:0]     log_cause
);
  // R8
  pgood_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> rail_en);

  // R8
  ramp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en) |-> !pgood);

  // R1
  ov_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_vld && log_cause[0]) |-> (!rail_en && !pgood));

  // R1
  ov_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_vld && log_cause[0]) |=> !rail_en);

  // R5
  phase_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_vld && log_cause[4] && log_cause[3:0] == 4'b0 && !log_cause[6]) |-> rail_en);

  // R7
  ph_logged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ph_off & ~$past(ph_off))) |-> log_vld);
endmodule

bind vr_fault_policy vr_fault_policy_chk #(.NPH(NPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .pgood(pgood),
  .ph_off(ph_off), .log_vld(log_vld), .log_cause(log_cause)
);

// File: tb/sim_vr_fault_policy.sv
module sim_vr_fault_policy;
  localparam int NPH = 4, VW = 12, IW = 12, TW = 10, CW = 16, FW = 4, RW = 3, TSW = 32;
  localparam int PW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, run_req, clr_latch, load_step;
  logic [VW-1:0] v_code, ov_lim, uv_lim;
  logic [IW-1:0] i_total, oct_lim, short_lim, oph_lim;
  logic [NPH*IW-1:0] i_phase;
  logic [NPH*TW-1:0] t_phase;
  logic [TW-1:0] t_ctrl, t_warn, t_hot;
  logic [FW-1:0] ov_filt;
  logic [CW-1:0] uv_blank, start_len, oc_cool, ph_cool, hot_deb, good_len;
  logic [RW-1:0] retry_max;
  logic rail_en, derate, pgood, log_vld;
  logic [NPH-1:0] ph_off;
  logic [TSW-1:0] log_ts;
  logic [6:0] log_cause;
  logic [3:0] log_rail;
  logic [PW-1:0] log_phase;
  logic [IW-1:0] log_cur;
  logic [TW-1:0] log_tmp;

  vr_fault_policy #(.NPH(NPH), .VW(VW), .IW(IW), .TW(TW), .CW(CW), .FW(FW), .RW(RW),
                    .TSW(TSW), .TICK_DIV(4), .RAIL_ID(5)) u0 (.*);

  int nchk = 0, nerr = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct packed {
    logic [9:0] t0, t1, t2, t3, tc;
    logic       d;
  } vec_t;
  localparam vec_t VEC [6] = '{
    '{10'd50,  10'd50,  10'd50,  10'd50,  10'd50,  1'b0},
    '{10'd50,  10'd50,  10'd101, 10'd50,  10'd50,  1'b1},
    '{10'd50,  10'd50,  10'd50,  10'd50,  10'd101, 1'b1},
    '{10'd100, 10'd50,  10'd50,  10'd50,  10'd100, 1'b0},
    '{10'd50,  10'd50,  10'd50,  10'd119, 10'd50,  1'b1},
    '{10'd99,  10'd99,  10'd99,  10'd99,  10'd99,  1'b0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_log(input int n, output bit got);
    got = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (log_vld) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic pulse_len(output int hi, output int lo);
    for (int i = 0; i < 200 && !rail_en; i++) @(negedge clk);
    hi = 0;
    while (rail_en && hi < 200) begin hi++; @(negedge clk); end
    lo = 0;
    while (!rail_en && lo < 200) begin lo++; @(negedge clk); end
  endtask

  task automatic clear_latch();
    clr_latch = 1'b1; step(1); clr_latch = 1'b0;
  endtask

  task automatic trip_oc();
    i_total = 12'd1100; step(1); i_total = 12'd400;
  endtask

  bit done = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    bit got;
    int ts_a, cyc_a, h1, d1, h2, d2, h3, d3;
    rst_n = 1'b0; run_req = 1'b0; clr_latch = 1'b0; load_step = 1'b0;
    v_code = 12'd2500; i_total = 12'd400;
    i_phase = {4{12'd100}}; t_phase = {4{10'd50}}; t_ctrl = 10'd50;
    ov_lim = 12'd3000; uv_lim = 12'd2000; oct_lim = 12'd1000; short_lim = 12'd1500;
    oph_lim = 12'd300; t_warn = 10'd100; t_hot = 10'd120; ov_filt = 4'd2;
    uv_blank = 16'd5; start_len = 16'd3; oc_cool = 16'd4; ph_cool = 16'd6;
    hot_deb = 16'd5; good_len = 16'd20; retry_max = 3'd2;
    step(3);
    check("R11 rail_en in reset", rail_en, 0);
    check("R11 pgood in reset", pgood, 0);
    check("R11 ph_off in reset", ph_off, 0);
    check("R11 derate in reset", derate, 0);
    check("R11 log_vld in reset", log_vld, 0);
    rst_n = 1'b1; run_req = 1'b1;
    step(2);
    check("R8 rail on during ramp", rail_en, 1);
    check("R8 pgood low during ramp", pgood, 0);
    step(40);
    check("R8 pgood after ramp", pgood, 1);

    // R6 derate table
    for (int n = 0; n < 6; n++) begin
      t_phase = {VEC[n].t3, VEC[n].t2, VEC[n].t1, VEC[n].t0};
      t_ctrl  = VEC[n].tc;
      step(2);
      check($sformatf("R6 derate vec%0d", n), derate, VEC[n].d);
      check($sformatf("R6 no gating vec%0d", n), {pgood, ph_off}, 5'b10000);
    end
    t_phase = {4{10'd50}}; t_ctrl = 10'd50;
    step(2);

    // R1 short excursion
    v_code = 12'd3100; step(2); v_code = 12'd2500; step(4);
    check("R1 short overvoltage ignored", {rail_en, pgood}, 2'b11);
    // R1 trip
    v_code = 12'd3100; step(2);
    check("R1 filter not yet expired", rail_en, 1);
    step(1);
    check("R1 rail off on trip", {rail_en, pgood}, 2'b00);
    check("R7 log strobe ov", log_vld, 1);
    check("R7 cause ov", log_cause, 7'b0000001);
    check("R7 rail id", log_rail, 5);
    ts_a = int'(log_ts); cyc_a = cyc;
    step(1);
    check("R7 strobe single cycle", log_vld, 0);
    v_code = 12'd2500; step(40);
    check("R1 latched off", rail_en, 0);
    clear_latch(); step(40);
    check("R1 restart after clear", pgood, 1);

    // R5 phase overcurrent
    i_phase[2*IW +: IW] = 12'd350; step(1);
    check("R5 phase 2 off", ph_off, 4'b0100);
    check("R5 rail stays on", {rail_en, pgood}, 2'b11);
    check("R7 cause phase oc", log_cause, 7'b0010000);
    check("R7 phase id", log_phase, 2);
    check("R7 phase current snapshot", log_cur, 350);
    check("R7 phase temp snapshot", log_tmp, 50);
    i_phase[2*IW +: IW] = 12'd100; step(10);
    check("R5 phase held during cool-down", ph_off, 4'b0100);
    step(30);
    check("R5 phase re-added", ph_off, 4'b0000);

    // R6 phase hot
    t_phase[1*TW +: TW] = 10'd125; step(2);
    check("R6 derate on hot phase", derate, 1);
    step(6);
    check("R6 phase not gated before debounce", ph_off, 4'b0000);
    wait_log(40, got);
    check("R6 phase hot logged", got, 1);
    check("R7 cause phase hot", log_cause, 7'b0100000);
    check("R6 phase 1 gated", ph_off, 4'b0010);
    check("R7 hot phase temp snapshot", log_tmp, 125);
    check("R6 rail kept on", rail_en, 1);
    t_phase[1*TW +: TW] = 10'd50; step(60);
    check("R6 phase re-added after cooling", ph_off, 4'b0000);

    // R6 controller hot, brief then sustained
    t_ctrl = 10'd125; step(8); t_ctrl = 10'd50; step(4);
    check("R6 brief controller heat ignored", {rail_en, pgood}, 2'b11);
    t_ctrl = 10'd125;
    wait_log(60, got);
    check("R6 controller hot logged", got, 1);
    check("R7 cause controller hot", log_cause, 7'b1000000);
    check("R6 rail off on controller hot", rail_en, 0);
    check("R7 total current snapshot", log_cur, 400);
    check("R7 controller temp snapshot", log_tmp, 125);
    check("R7 timestamp delta", log_ts - TSW'(ts_a), TSW'(cyc - cyc_a));
    t_ctrl = 10'd50; step(40);
    check("R6 controller hot latched", rail_en, 0);
    clear_latch(); step(40);
    check("R6 restart after clear", pgood, 1);
    step(40);

    // R2 undervoltage blanking
    load_step = 1'b1; step(1); load_step = 1'b0; v_code = 12'd1900;
    step(8);
    check("R2 undervoltage blanked", pgood, 1);
    wait_log(40, got);
    check("R2 undervoltage logged", got, 1);
    check("R7 cause uv", log_cause, 7'b0001000);
    check("R2 rail off on uv", {rail_en, pgood}, 2'b00);
    v_code = 12'd2500; step(40);
    check("R2 held off with run_req high", rail_en, 0);
    run_req = 1'b0; step(2); run_req = 1'b1; step(40);
    check("R2 restart after run_req cycle", pgood, 1);

    // R3 hiccup and retry limit
    trip_oc();
    check("R7 cause total oc", log_cause, 7'b0000010);
    check("R3 rail off on oc", rail_en, 0);
    step(5);
    check("R3 cooling", rail_en, 0);
    step(45);
    check("R3 first retry runs", pgood, 1);
    trip_oc(); step(50);
    check("R3 second retry runs", pgood, 1);
    trip_oc(); step(80);
    check("R3 latched after retry limit", rail_en, 0);
    clear_latch(); step(40);
    check("R3 restart after clear", pgood, 1);

    // R4 retry count cleared by good period
    trip_oc(); step(50);
    check("R4 retry after trip", pgood, 1);
    step(100);
    trip_oc(); step(50);
    check("R4 retry after second trip", pgood, 1);
    trip_oc(); step(50);
    check("R4 third trip restarts after good period", pgood, 1);
    step(120);

    // R9 start-up short with doubling back-off
    run_req = 1'b0; step(4); i_total = 12'd1600; run_req = 1'b1;
    pulse_len(h1, d1);
    pulse_len(h2, d2);
    pulse_len(h3, d3);
    check("R9 fast shutdown first", h1, 1);
    check("R9 fast shutdown second", h2, 1);
    check("R9 first back-off length", (d1 >= 12 && d1 <= 20), 1);
    check("R9 second back-off doubled", (d2 >= 28 && d2 <= 36), 1);
    check("R9 latched after retries", d3, 200);
    check("R7 cause short", log_cause, 7'b0000100);
    i_total = 12'd400; clear_latch(); step(40);
    check("R9 restart after clear", pgood, 1);
    step(40);

    // R10 priority
    ov_filt = 4'd0; v_code = 12'd3100; i_total = 12'd1100; step(1);
    check("R10 both logged ov+oc", log_cause, 7'b0000011);
    check("R10 rail off", rail_en, 0);
    v_code = 12'd2500; i_total = 12'd400; step(80);
    check("R10 ov action wins (latched)", rail_en, 0);
    ov_filt = 4'd2; clear_latch(); step(80);
    check("R10 restart after clear", pgood, 1);
    v_code = 12'd1900; i_total = 12'd1100; step(1);
    check("R10 both logged oc+uv", log_cause, 7'b0001010);
    check("R10 rail off oc+uv", rail_en, 0);
    v_code = 12'd2500; i_total = 12'd400; step(50);
    check("R10 oc action wins (hiccup restarts)", pgood, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule